// File: doc/BRIEF.md
# Pin-Function Protection Gate

This block guards the per-pin function-select register of an 8-pin peripheral port. Software first writes a 32-bit key to open the gate, then loads a per-bit commit mask. It can close the gate again by writing any other value. A write to the function-select register changes only those pins whose commit bit is set, so a pin whose commit bit is clear keeps its function even when software writes the whole register carelessly.

The block also holds eight plain 8-bit pad-control registers: drive strengths, open drain, pull-up, pull-down, slew and digital enable. They sit on the same simple synchronous register bus. A write takes effect on the clock edge that samples the strobe. Read data is a combinational function of the address and the current register contents. The function-select vector is driven out continuously, so the port's pin multiplexer can use it.

Top module: `pinmux_guard`

## Requirements
- R1: A write of exactly 0x0ACCE551 (all 32 bits compared) to address 0x520 clears the locked state. A write of any other 32-bit value to 0x520 sets it.
- R2: A read of address 0x520 returns 1 while locked and 0 while unlocked. Bits 31..1 read as zero.
- R3: While unlocked, a write to address 0x524 stores the low 8 data bits as the commit mask. While locked, such a write leaves the mask unchanged. A read of 0x524 returns the mask, zero-extended.
- R4: After reset the block is locked and the commit mask is 0xFF.
- R5: A write to address 0x420 sets each function-select bit whose commit bit is 1 to the matching data bit. Every bit whose commit bit is 0 keeps its value. The commit mask used is the one held in the cycle of the write.
- R6: The output `fn_sel` always equals the function-select register, which resets to 0x00 and changes only on writes to 0x420. A read of 0x420 returns it, zero-extended.
- R7: Eight pad-control registers sit at 0x500 + 4*i for i = 0..7. Each is a plain 8-bit read/write register that resets to 0x00, stores the low 8 data bits and reads back zero-extended. A write to one of them leaves the other seven unchanged.
- R8: A read of any other address returns zero. A write to any other address changes no register.
- R9: A write becomes visible on the clock edge that samples `bus_we`, not earlier. Read data follows a change of address within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| fn_sel | output | 8 | Current function-select vector, one bit per pin |

## Verification
The assertions assume that the bus inputs are stable and known at each rising edge, and that each cycle carries at most one access, so a key write and a commit write never share a cycle. The bench changes the address, data and strobe only on falling edges and drops the strobe after one cycle. This keeps every write a single clean strobe that the checker can pair with the register change in the next cycle. The bench sweeps every commit mask, with a locked attempt to change the mask in each step. It tries every single-bit corruption of the key and every pad-control index, so every masked-update path is reached.

// File: rtl/pmg_pkg.sv
`timescale 1ns/1ps
package pmg_pkg;

    // Register offsets; the bus decoder depends on these exact values.
    localparam int unsigned FNSEL_OFS   = 32'h420;
    localparam int unsigned PADCTL_BASE = 32'h500;
    localparam int unsigned KEY_OFS     = 32'h520;
    localparam int unsigned COMMIT_OFS  = 32'h524;

    localparam logic [31:0] UNLOCK_WORD = 32'h0ACC_E551;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_FNSEL,
        TGT_PAD,
        TGT_KEY,
        TGT_COMMIT
    } tgt_e;

endpackage

// File: rtl/pmg_lock_gate.sv
`timescale 1ns/1ps
module pmg_lock_gate #(
    parameter int unsigned PIN_W  = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY = DATA_W'(pmg_pkg::UNLOCK_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              commit_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked,
    output logic [PIN_W-1:0]  commit_mask
);

    typedef struct packed {
        logic             locked;
        logic [PIN_W-1:0] mask;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            st_d.locked = (wdata != KEY);
        end
        if (commit_wr && !st_q.locked) begin
            st_d.mask = wdata[PIN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked      = st_q.locked;
    assign commit_mask = st_q.mask;

endmodule

// File: rtl/pmg_masked_reg.sv
`timescale 1ns/1ps
module pmg_masked_reg #(
    parameter int unsigned PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [PIN_W-1:0] wdata,
    input  logic [PIN_W-1:0] bit_en,
    output logic [PIN_W-1:0] value
);

    logic [PIN_W-1:0] val_d, val_q;

    // One update lane per pin: a lane moves only when written and enabled.
    for (genvar b = 0; b < PIN_W; b++) begin : g_lane
        always_comb begin
            val_d[b] = val_q[b];
            if (wr && bit_en[b]) begin
                val_d[b] = wdata[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign value = val_q;

endmodule

// File: rtl/pmg_pad_bank.sv
`timescale 1ns/1ps
module pmg_pad_bank #(
    parameter int unsigned PIN_W   = 8,
    parameter int unsigned NUM_REG = 8,
    localparam int unsigned IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [PIN_W-1:0]                wdata,
    output logic [NUM_REG-1:0][PIN_W-1:0]   regs
);

    logic [NUM_REG-1:0][PIN_W-1:0] bank_d, bank_q;

    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
        always_comb begin
            bank_d[i] = bank_q[i];
            if (wr && (wr_idx == IDX_W'(i))) begin
                bank_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs = bank_q;

endmodule

// File: rtl/pinmux_guard.sv
`timescale 1ns/1ps
module pinmux_guard #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PIN_W   = 8,
    parameter int unsigned NUM_PAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PIN_W-1:0]  fn_sel
);

    import pmg_pkg::*;

    localparam int unsigned IDX_W    = (NUM_PAD > 1) ? $clog2(NUM_PAD) : 1;
    localparam int unsigned PAD_SPAN = NUM_PAD * 4;

    tgt_e              tgt;
    logic [ADDR_W-1:0] pad_off;
    logic [IDX_W-1:0]  pad_idx;

    logic                          lock_st;
    logic [PIN_W-1:0]              cmt_mask;
    logic [NUM_PAD-1:0][PIN_W-1:0] pad_regs;

    // Address decode
    always_comb begin
        pad_off = bus_addr - ADDR_W'(PADCTL_BASE);
        pad_idx = pad_off[IDX_W+1:2];
        tgt     = TGT_NONE;
        if (bus_addr == ADDR_W'(FNSEL_OFS)) begin
            tgt = TGT_FNSEL;
        end else if (bus_addr == ADDR_W'(KEY_OFS)) begin
            tgt = TGT_KEY;
        end else if (bus_addr == ADDR_W'(COMMIT_OFS)) begin
            tgt = TGT_COMMIT;
        end else if ((pad_off < ADDR_W'(PAD_SPAN)) && (pad_off[1:0] == 2'b00)) begin
            tgt = TGT_PAD;
        end
    end

    pmg_lock_gate #(
        .PIN_W  (PIN_W),
        .DATA_W (DATA_W)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (bus_we && (tgt == TGT_KEY)),
        .commit_wr   (bus_we && (tgt == TGT_COMMIT)),
        .wdata       (bus_wdata),
        .locked      (lock_st),
        .commit_mask (cmt_mask)
    );

    pmg_masked_reg #(
        .PIN_W (PIN_W)
    ) u_fnsel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_we && (tgt == TGT_FNSEL)),
        .wdata  (bus_wdata[PIN_W-1:0]),
        .bit_en (cmt_mask),
        .value  (fn_sel)
    );

    pmg_pad_bank #(
        .PIN_W   (PIN_W),
        .NUM_REG (NUM_PAD)
    ) u_pads (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_we && (tgt == TGT_PAD)),
        .wr_idx (pad_idx),
        .wdata  (bus_wdata[PIN_W-1:0]),
        .regs   (pad_regs)
    );

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (tgt)
            TGT_FNSEL:  bus_rdata[PIN_W-1:0] = fn_sel;
            TGT_PAD:    bus_rdata[PIN_W-1:0] = pad_regs[pad_idx];
            TGT_KEY:    bus_rdata[0]         = lock_st;
            TGT_COMMIT: bus_rdata[PIN_W-1:0] = cmt_mask;
            default:    bus_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/pmg_guard_chk.sv
`timescale 1ns/1ps
module pmg_guard_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PIN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PIN_W-1:0]  fn_sel,
    input logic              locked,
    input logic [PIN_W-1:0]  commit_mask
);

    import pmg_pkg::*;

    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(KEY_OFS);
    localparam logic [ADDR_W-1:0] A_CMT = ADDR_W'(COMMIT_OFS);
    localparam logic [ADDR_W-1:0] A_FN  = ADDR_W'(FNSEL_OFS);
    localparam logic [DATA_W-1:0] KEYV  = DATA_W'(UNLOCK_WORD);

    AST_KEY_DECIDES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_KEY) |=> (locked == ($past(bus_wdata) != KEYV))); // R1

    AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_KEY) |-> (bus_rdata == DATA_W'(locked))); // R2

    AST_COMMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_we && bus_addr == A_CMT) |=> $stable(commit_mask)); // R3

    AST_UNCOMMITTED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_FN) |=>
        (((fn_sel ^ $past(fn_sel)) & ~$past(commit_mask)) == '0)); // R5

    AST_COMMITTED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_FN) |=>
        (((fn_sel ^ $past(bus_wdata[PIN_W-1:0])) & $past(commit_mask)) == '0)); // R5

    AST_FNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_FN) |=> $stable(fn_sel)); // R6

endmodule

bind pinmux_guard pmg_guard_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PIN_W  (PIN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .fn_sel      (fn_sel),
    .locked      (lock_st),
    .commit_mask (cmt_mask)
);

// File: tb/pinmux_guard_tb.sv
`timescale 1ns/1ps
module pinmux_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  fn_sel;

    int checks = 0;
    int errors = 0;

    // Reference state computed from the requirements
    logic       m_lock;
    logic [7:0] m_cmt;
    logic [7:0] m_fn;
    logic [7:0] m_pad [8];

    localparam logic [31:0] KEY = 32'h0ACC_E551;

    always #5 clk = ~clk;

    pinmux_guard u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fn_sel    (fn_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Reference update, derived from R1, R3, R5, R7, R8
    task automatic model_wr(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h520) m_lock = (d != KEY);
        else if (a == 12'h524) begin
            if (!m_lock) m_cmt = d[7:0];
        end else if (a == 12'h420) m_fn = (m_fn & ~m_cmt) | (d[7:0] & m_cmt);
        else if (a >= 12'h500 && a <= 12'h51C && a[1:0] == 2'b00) m_pad[(a - 12'h500) >> 2] = d[7:0];
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic chk_all(input string req);
        logic [31:0] v;
        rd(12'h520, v); chk({req, " lock"}, v, {31'b0, m_lock});
        rd(12'h524, v); chk({req, " commit"}, v, {24'b0, m_cmt});
        rd(12'h420, v); chk({req, " fnsel"}, v, {24'b0, m_fn});
        chk({req, " fn_sel port"}, {24'b0, fn_sel}, {24'b0, m_fn});
        for (int i = 0; i < 8; i++) begin
            rd(12'h500 + 12'(4 * i), v); chk({req, " pad"}, v, {24'b0, m_pad[i]});
        end
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        m_lock = 1'b1; m_cmt = 8'hFF; m_fn = 8'h00;
        for (int i = 0; i < 8; i++) m_pad[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 R6 R7: reset state
        chk_all("R4 reset");

        // R1 R2: exact key unlocks; each single-bit corruption locks
        for (int b = 0; b < 32; b++) begin
            wr(12'h520, KEY);
            rd(12'h520, v); chk("R1 R2 unlock", v, 32'd0);
            wr(12'h520, KEY ^ (32'd1 << b));
            rd(12'h520, v); chk("R1 R2 bad key locks", v, 32'd1);
        end

        // R3 R5: sweep every commit mask, with a locked attempt to change it
        for (int m = 0; m < 256; m++) begin
            wr(12'h520, KEY);
            wr(12'h524, 32'hABCD_0000 | 32'(m));
            wr(12'h520, 32'h0);
            wr(12'h524, 32'(~m) & 32'hFF);
            rd(12'h524, v); chk("R3 commit frozen while locked", v, 32'(m));
            wr(12'h420, 32'hFFFF_FF00 | 32'((m * 37 + 11) ^ 8'hA5));
            rd(12'h420, v); chk("R5 masked fn update", v, {24'b0, m_fn});
            chk("R6 fn_sel port", {24'b0, fn_sel}, {24'b0, m_fn});
        end

        // R9: write not visible before the sampling edge, visible after it
        wr(12'h520, KEY); wr(12'h524, 32'hFF);
        @(negedge clk);
        bus_addr = 12'h420; bus_wdata = {24'b0, ~m_fn}; bus_we = 1'b1;
        #1 chk("R9 not yet written", {24'b0, fn_sel}, {24'b0, m_fn});
        @(negedge clk);
        bus_we = 1'b0;
        m_fn = ~m_fn;
        chk("R9 written after edge", {24'b0, fn_sel}, {24'b0, m_fn});
        bus_addr = 12'h524;
        #1 chk("R9 read follows address", bus_rdata, 32'hFF);

        // R7: pad registers, upper data bits dropped, no cross-talk
        for (int i = 0; i < 8; i++) begin
            wr(12'h500 + 12'(4 * i), 32'hDEAD_BE00 | 32'(i * 17 + 3));
        end
        chk_all("R7 pads");
        wr(12'h50C, 32'h5A);
        chk_all("R7 single pad write");

        // R8: unmapped reads return zero and writes change nothing
        wr(12'h528, 32'hFFFF_FFFF);
        wr(12'h41C, 32'hFFFF_FFFF);
        wr(12'h502, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        chk_all("R8 unmapped write");
        rd(12'h000, v); chk("R8 read 0x000", v, 32'd0);
        rd(12'h528, v); chk("R8 read 0x528", v, 32'd0);
        rd(12'h502, v); chk("R8 read 0x502", v, 32'd0);
        rd(12'hFFC, v); chk("R8 read 0xFFC", v, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule